// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block rearranges the elements of one vector register under control of a Boolean mask and a run-time vector length. In compress mode it walks the mask from element 0 upward and packs every selected source element, in order, into the lowest result positions. It zero-fills the positions above them and reports how many elements were selected. In expand mode it does the inverse. Consecutive packed source elements, starting at source element 0, are placed into the result positions whose mask bit is set. Every other position keeps the value supplied on a separate old-destination input.

A requested vector length above the maximum vector length is clamped to it. Mask bits at or above the effective length are treated as clear. The unit steps through one element per clock after a start strobe, pulses done for one cycle when the result is final, and ignores start while it is working. Result and count hold their values from done until the next accepted start.

Top module: `vmask_perm_unit`

## Requirements
- R1: After reset, done_o is 0, count_o is 0 and result_o is all zero.
- R2: In compress mode (mode_i = 0) the k-th selected source element, counting from element 0 upward, appears at result position k.
- R3: In compress mode every result position at or above count_o is zero when done_o is high.
- R4: At done, count_o equals the number of set mask bits below the effective vector length, in both modes.
- R5: In expand mode (mode_i = 1) the k-th set mask bit, counting from position 0 upward, receives source element k.
- R6: In expand mode every result position whose effective mask bit is clear holds the old_i element at that position.
- R7: A vlen_i value above LANES is treated as LANES.
- R8: Mask bits at positions at or above the effective vector length have no effect on result_o or count_o.
- R9: done_o is high for exactly one cycle. It rises max(L,1) clock edges after the edge that accepts start, where L is the effective length.
- R10: A start strobe while the unit is busy is ignored; the running operation completes with its own inputs.
- R11: With an effective length of 0, count_o is 0, a compress result is all zero and an expand result equals old_i.

Element i of any vector port occupies bits [i*EW +: EW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mode_i | input | 1 | 0 = compress, 1 = expand |
| mask_i | input | LANES | Element mask, bit i selects element i |
| vlen_i | input | VLW | Requested vector length |
| src_i | input | LANES*EW | Source vector |
| old_i | input | LANES*EW | Old destination vector (expand mode) |
| result_o | output | LANES*EW | Result vector |
| count_o | output | $clog2(LANES+1) | Number of active selected elements |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit at its defaults: eight 16-bit lanes and a 4-bit length input. The length input can therefore carry values from 9 to 15, so clamping is reached directly, along with lengths of 0 and 8. With only eight lanes, random masks regularly produce the empty mask, the full mask and single-bit masks. The bench also checks the exact done latency for each length, and a start strobe raised in the middle of a run.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

  typedef enum logic {
    VMP_COMPRESS = 1'b0,
    VMP_EXPAND   = 1'b1
  } vmp_mode_e;

  typedef enum logic [1:0] {
    VMP_IDLE = 2'd0,
    VMP_RUN  = 2'd1,
    VMP_FIN  = 2'd2
  } vmp_state_e;

  // Clamp a requested length to the lane count.
  function automatic int unsigned vmp_clamp(input int unsigned req, input int unsigned mvl);
    return (req > mvl) ? mvl : req;
  endfunction

  // Steps taken by a run: one per element, at least one.
  function automatic int unsigned vmp_steps(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

endpackage

// File: rtl/vmp_len_prep.sv
module vmp_len_prep #(
  parameter int LANES = 8,
  parameter int VLW   = 4,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [VLW-1:0]   vlen_req,
  input  logic [LANES-1:0] mask_raw,
  output logic [CW-1:0]    vl_eff,
  output logic [LANES-1:0] mask_eff
);
  import vmp_pkg::*;

  assign vl_eff = CW'(vmp_clamp(int'(vlen_req), LANES));

  for (genvar g = 0; g < LANES; g++) begin : g_trim
    assign mask_eff[g] = mask_raw[g] && (int'(vl_eff) > g);
  end

endmodule

// File: rtl/vmp_seq.sv
module vmp_seq #(
  parameter int LANES = 8,
  localparam int CW   = $clog2(LANES + 1),
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] vl_eff,
  output logic          accept,
  output logic          step_valid,
  output logic [IW-1:0] idx,
  output logic          last_step,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] vl_q
);
  import vmp_pkg::*;

  vmp_state_e state_q, state_d;
  logic [IW-1:0] idx_q;

  assign accept     = start && (state_q == VMP_IDLE);
  assign step_valid = (state_q == VMP_RUN);
  assign busy       = (state_q != VMP_IDLE);
  assign done       = (state_q == VMP_FIN);
  assign idx        = idx_q;
  assign last_step  = step_valid && ((vl_q == '0) || ((CW'(idx_q) + CW'(1)) == vl_q));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      VMP_IDLE: if (accept) state_d = VMP_RUN;
      VMP_RUN:  if (last_step) state_d = VMP_FIN;
      VMP_FIN:  state_d = VMP_IDLE;
      default:  state_d = VMP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VMP_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q <= '0;
        vl_q  <= vl_eff;
      end else if (step_valid && !last_step) begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(vl_q));

  // R9
  run_to_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

endmodule

// File: rtl/vmp_lane_path.sv
module vmp_lane_path #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  localparam int CW   = $clog2(LANES + 1),
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              mode_in,
  input  logic [LANES-1:0]  mask_in,
  input  logic [LANES*EW-1:0] src_in,
  input  logic [LANES*EW-1:0] old_in,
  input  logic              step_valid,
  input  logic [IW-1:0]     idx,
  output logic [LANES*EW-1:0] result,
  output logic [CW-1:0]     ptr,
  output logic              mode_q,
  output logic [LANES-1:0]  mask_q
);
  import vmp_pkg::*;

  logic [EW-1:0] src_q [LANES];
  logic [EW-1:0] res_q [LANES];
  logic [CW-1:0] ptr_q;
  logic          take;
  logic [IW-1:0] ptr_lane;

  assign take     = step_valid && mask_q[idx];
  assign ptr_lane = ptr_q[IW-1:0];
  assign ptr      = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= '0;
      ptr_q  <= '0;
      for (int i = 0; i < LANES; i++) begin
        src_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else if (accept) begin
      mode_q <= mode_in;
      mask_q <= mask_in;
      ptr_q  <= '0;
      for (int i = 0; i < LANES; i++) begin
        src_q[i] <= src_in[i*EW +: EW];
        res_q[i] <= (mode_in == VMP_EXPAND) ? old_in[i*EW +: EW] : '0;
      end
    end else if (take) begin
      ptr_q <= ptr_q + CW'(1);
      if (mode_q == VMP_EXPAND) res_q[idx]      <= src_q[ptr_lane];
      else                      res_q[ptr_lane] <= src_q[idx];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign result[g*EW +: EW] = res_q[g];
  end

  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (int'(ptr_q) < LANES));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !take) |=> $stable(ptr_q));

endmodule

// File: rtl/vmask_perm_unit.sv
module vmask_perm_unit #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  parameter int VLW   = 4,
  localparam int CW   = $clog2(LANES + 1),
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic [VLW-1:0]      vlen_i,
  input  logic [LANES*EW-1:0] src_i,
  input  logic [LANES*EW-1:0] old_i,
  output logic [LANES*EW-1:0] result_o,
  output logic [CW-1:0]       count_o,
  output logic                done_o
);
  import vmp_pkg::*;

  logic [CW-1:0]    vl_eff, vl_q;
  logic [LANES-1:0] mask_eff, mask_q;
  logic             accept, step_valid, last_step, busy, mode_q;
  logic [IW-1:0]    idx;

  vmp_len_prep #(.LANES(LANES), .VLW(VLW)) u_prep (
    .vlen_req (vlen_i),
    .mask_raw (mask_i),
    .vl_eff   (vl_eff),
    .mask_eff (mask_eff)
  );

  vmp_seq #(.LANES(LANES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .vl_eff     (vl_eff),
    .accept     (accept),
    .step_valid (step_valid),
    .idx        (idx),
    .last_step  (last_step),
    .busy       (busy),
    .done       (done_o),
    .vl_q       (vl_q)
  );

  vmp_lane_path #(.LANES(LANES), .EW(EW)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .mode_in    (mode_i),
    .mask_in    (mask_eff),
    .src_in     (src_i),
    .old_in     (old_i),
    .step_valid (step_valid),
    .idx        (idx),
    .result     (result_o),
    .ptr        (count_o),
    .mode_q     (mode_q),
    .mask_q     (mask_q)
  );

  // R7
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(vl_q) <= LANES));

  // R8
  mask_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((mask_q >> vl_q) == '0));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_o) |=> $stable(mode_q) && $stable(mask_q));

  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(count_o) == $countones(mask_q)));

  for (genvar g = 0; g < LANES; g++) begin : g_zero
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (mode_q == VMP_COMPRESS) && (int'(count_o) <= g))
        |-> (result_o[g*EW +: EW] == '0));
  end

endmodule

// File: tb/vmask_perm_unit_bench.sv
module vmask_perm_unit_bench;
  localparam int LANES = 8;
  localparam int EW    = 16;
  localparam int VLW   = 4;
  localparam int CW    = $clog2(LANES + 1);
  localparam int VW    = LANES * EW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [LANES-1:0] mask_i = '0;
  logic [VLW-1:0] vlen_i = '0;
  logic [VW-1:0] src_i = '0, old_i = '0;
  logic [VW-1:0] result_o;
  logic [CW-1:0] count_o;
  logic done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vmask_perm_unit #(.LANES(LANES), .EW(EW), .VLW(VLW)) u_vmask_perm_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .mask_i(mask_i), .vlen_i(vlen_i), .src_i(src_i), .old_i(old_i),
    .result_o(result_o), .count_o(count_o), .done_o(done_o)
  );

  function automatic int eff_len(input int v);
    return (v > LANES) ? LANES : v;
  endfunction

  function automatic int active(input logic [LANES-1:0] m, input int v);
    int n = 0;
    for (int i = 0; i < eff_len(v); i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic logic [VW-1:0] model(input bit expand, input logic [LANES-1:0] m,
                                          input int v, input logic [VW-1:0] s,
                                          input logic [VW-1:0] od);
    logic [VW-1:0] r;
    int k = 0;
    r = expand ? od : '0;
    for (int i = 0; i < eff_len(v); i++) begin
      if (m[i]) begin
        if (expand) r[i*EW +: EW] = s[k*EW +: EW];
        else        r[k*EW +: EW] = s[i*EW +: EW];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*EW +: EW] = EW'($urandom);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit expand, input logic [LANES-1:0] m, input int v,
                        input logic [VW-1:0] s, input logic [VW-1:0] od,
                        input bit poke, input string tag);
    logic [VW-1:0] exp_r;
    int edges;
    exp_r = model(expand, m, v, s, od);
    @(negedge clk);
    mode_i = expand; mask_i = m; vlen_i = VLW'(v); src_i = s; old_i = od; start_i = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    if (poke) begin
      // R10: disturbing start with fresh inputs while busy
      mode_i = ~expand; mask_i = ~m; vlen_i = VLW'(LANES); src_i = rnd_vec(); old_i = rnd_vec();
    end else begin
      start_i = 1'b0;
    end
    while (!done_o && edges < 40) begin
      @(posedge clk); edges++;
      @(negedge clk);
      start_i = 1'b0;
    end
    // R9
    check(edges == ((eff_len(v) == 0) ? 1 : eff_len(v)) + 1, {tag, " R9 latency"},
          VW'(edges), VW'(((eff_len(v) == 0) ? 1 : eff_len(v)) + 1));
    check(result_o == exp_r, {tag, expand ? " R5/R6 result" : " R2/R3 result"}, result_o, exp_r);
    // R4
    check(int'(count_o) == active(m, v), {tag, " R4 count"}, VW'(count_o), VW'(active(m, v)));
    @(negedge clk);
    // R9
    check(!done_o, {tag, " R9 single pulse"}, VW'(done_o), '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [VW-1:0] s, od;
    int unsigned seed_use;
    seed_use = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(!done_o && count_o == '0 && result_o == '0, "R1 reset", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && count_o == '0 && result_o == '0, "R1 after release", result_o, '0);

    s = rnd_vec(); od = rnd_vec();
    run_op(1'b0, 8'b1011_0110, 8, s, od, 1'b0, "R2 compress directed");
    run_op(1'b1, 8'b1011_0110, 8, s, od, 1'b0, "R5 expand directed");
    run_op(1'b0, 8'hFF, 8, s, od, 1'b0, "R2 full mask");
    run_op(1'b1, 8'h00, 8, s, od, 1'b0, "R6 empty mask");
    run_op(1'b0, 8'hFF, 15, s, od, 1'b0, "R7 clamp compress");
    run_op(1'b1, 8'hA5, 12, s, od, 1'b0, "R7 clamp expand");
    run_op(1'b0, 8'hFF, 3, s, od, 1'b0, "R8 compress trim");
    run_op(1'b1, 8'hF0, 5, s, od, 1'b0, "R8 expand trim");
    run_op(1'b0, 8'hFF, 0, s, od, 1'b0, "R11 compress len0");
    run_op(1'b1, 8'hFF, 0, s, od, 1'b0, "R11 expand len0");
    run_op(1'b0, 8'h80, 8, s, od, 1'b0, "R3 single top");
    run_op(1'b0, 8'b0110_1001, 6, s, od, 1'b1, "R10 compress poke");
    run_op(1'b1, 8'b1100_0011, 7, s, od, 1'b1, "R10 expand poke");

    for (int n = 0; n < 300; n++) begin
      run_op(bit'($urandom & 1), LANES'($urandom), int'($urandom % 16), rnd_vec(), rnd_vec(),
             ($urandom % 8) == 0, "random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule